// File: doc/BRIEF.md
# SATA Link Power State Controller

This block governs the interface power state of one host-side serial ATA port. Software supplies an aggressive power-management enable, a bit that picks slumber or partial for host-started entry, a 4-bit restriction field and a device-initiated-management enable. The block also watches an idle flag from the command engine, new-command pulses, and device-side entry and wake requests. From these it decides when the PHY leaves the active state, which low-power state it enters, and when it returns.

The states are S_NODEV (no device), S_ACTIVE (PHY ready), S_PARTIAL, S_SLUMBER, S_DEVSLP and S_WAKE (returning to ready). There are six named transitions. T_ATTACH goes from S_NODEV to S_ACTIVE when a device is present. T_HOST_ENTER goes from S_ACTIVE to a low state after the idle flag has been held long enough. T_DEV_ENTER goes from S_ACTIVE to a low state when the device asks for it. T_EXIT goes from any low state to S_WAKE on a new command or a device wake. T_READY goes from S_WAKE to S_ACTIVE when the PHY reports ready. T_DETACH goes from any state to S_NODEV when the device is removed.

While the port is in S_WAKE, a latency timer measures the time spent there against a limit chosen by the state being left, and it flags an overrun. A status field reports the power state so that software can confirm each transition.

Top module: `sata_lpm_ctrl`

## Requirements
- R1: During reset and in S_NODEV, `status_ipm` is 0 and `phy_mode` is 0. The first clock edge after reset with `dev_present`=1 moves the port to S_ACTIVE.
- R2: With `agg_en`=1, `port_idle` held, and no other event, S_ACTIVE stays in place for `idle_limit` edges and moves to a low state on the next edge. The target is S_SLUMBER when `agg_slumber`=1 and S_PARTIAL when it is 0.
- R3: With `agg_en`=0, the idle flag never starts host entry, however long it is held.
- R4: `ipm_restrict` value 1 forbids partial, 2 forbids slumber and 3 forbids both. The values 0 and 4 to 15 impose no restriction. A forbidden request leaves the port in S_ACTIVE.
- R5: A `dev_lp_req` pulse in S_ACTIVE moves the port on the next edge, but only when `dipm_en`=1. The `dev_lp_kind` codes are 0 for partial, 1 for slumber and 2 for device sleep. Kinds 0 and 1 pass the R4 check, and kind 2 is not restricted. A device request takes priority over host entry in the same cycle.
- R6: In any low state, `new_cmd` or `dev_wake` moves the port to S_WAKE. In S_WAKE, `phy_mode` is 0 and `status_ipm` keeps the code of the state being left. The port reaches S_ACTIVE on the edge after `phy_ready` is seen.
- R7: Counting edges from entry into S_WAKE, `wake_err` is 1 for exactly one cycle after the limit number of edges if `phy_ready` is still 0. The limit is `PARTIAL_LIM`, `SLUMBER_LIM` or `DEVSLP_LIM`, chosen by the state being left.
- R8: The `status_ipm` codes are 1 for active, 2 for partial, 6 for slumber, 8 for device sleep and 0 for no device. The `phy_mode` codes are 0 for active or waking, 1 for partial, 2 for slumber and 3 for device sleep.
- R9: `dev_present`=0 sends the port to S_NODEV on the next edge from any state.
- R10: A `new_cmd` pulse in S_ACTIVE restarts the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| agg_en | input | 1 | Aggressive host-started entry enable |
| agg_slumber | input | 1 | Host entry target: 1 slumber, 0 partial |
| ipm_restrict | input | 4 | Low-power restriction field |
| dipm_en | input | 1 | Accept device-started entry |
| idle_limit | input | IDLE_W | Idle cycles required before host entry |
| dev_present | input | 1 | Device attached |
| port_idle | input | 1 | Command engine idle |
| new_cmd | input | 1 | New command pulse |
| dev_lp_req | input | 1 | Device low-power request pulse |
| dev_lp_kind | input | 2 | Kind of device request |
| dev_wake | input | 1 | Device wake request |
| phy_ready | input | 1 | PHY reports ready |
| phy_mode | output | 2 | Power state requested of the PHY |
| status_ipm | output | 4 | Reported power state |
| wake_err | output | 1 | Wake latency overrun pulse |

## Verification
The bench builds the block with `IDLE_W`=6 and wake limits of 6, 12 and 20 cycles in place of the millisecond-scale defaults. With these values the exact edge at which `wake_err` fires can be reached and checked for every low state, within a few dozen cycles each. The small idle width also lets the bench count idle entry, and its restart after a command, edge by edge.

// File: rtl/sata_lpm_pkg.sv
package sata_lpm_pkg;
    typedef enum logic [2:0] {
        S_NODEV, S_ACTIVE, S_PARTIAL, S_SLUMBER, S_DEVSLP, S_WAKE
    } lpm_state_t;

    typedef enum logic [1:0] {
        K_PARTIAL = 2'd0,
        K_SLUMBER = 2'd1,
        K_DEVSLP  = 2'd2,
        K_NONE    = 2'd3
    } lp_kind_t;

    localparam logic [3:0] ST_CODE_NODEV   = 4'd0;
    localparam logic [3:0] ST_CODE_ACTIVE  = 4'd1;
    localparam logic [3:0] ST_CODE_PARTIAL = 4'd2;
    localparam logic [3:0] ST_CODE_SLUMBER = 4'd6;
    localparam logic [3:0] ST_CODE_DEVSLP  = 4'd8;
endpackage

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer #(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              clear,
    input  logic [IDLE_W-1:0] limit,
    output logic              hit
);
    logic [IDLE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !count_en) begin
            cnt_q <= '0;
        end else if (cnt_q != {IDLE_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = count_en && !clear && (cnt_q >= limit);
endmodule

// File: rtl/lpm_entry_policy.sv
module lpm_entry_policy
    import sata_lpm_pkg::*;
(
    input  logic       agg_en,
    input  logic       agg_slumber,
    input  logic       idle_hit,
    input  logic [3:0] ipm_restrict,
    input  logic       dipm_en,
    input  logic       dev_lp_req,
    input  logic [1:0] dev_lp_kind,
    output lp_kind_t   go_kind
);
    logic no_partial, no_slumber, dev_ok, host_ok;
    lp_kind_t host_kind, dev_kind;

    always_comb begin
        no_partial = (ipm_restrict == 4'd1) || (ipm_restrict == 4'd3);
        no_slumber = (ipm_restrict == 4'd2) || (ipm_restrict == 4'd3);
        host_kind  = agg_slumber ? K_SLUMBER : K_PARTIAL;
        host_ok    = agg_en && idle_hit &&
                     !(agg_slumber ? no_slumber : no_partial);
        dev_kind   = lp_kind_t'(dev_lp_kind);
        unique case (dev_kind)
            K_PARTIAL: dev_ok = !no_partial;
            K_SLUMBER: dev_ok = !no_slumber;
            K_DEVSLP:  dev_ok = 1'b1;
            default:   dev_ok = 1'b0;
        endcase
        dev_ok = dev_ok && dipm_en && dev_lp_req;
        if (dev_ok)       go_kind = dev_kind;
        else if (host_ok) go_kind = host_kind;
        else              go_kind = K_NONE;
    end
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer
    import sata_lpm_pkg::*;
#(
    parameter int PARTIAL_LIM = 1000,
    parameter int SLUMBER_LIM = 1000000,
    parameter int DEVSLP_LIM  = 2000000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     waking,
    input  lp_kind_t src,
    input  logic     ready,
    output logic     err
);
    localparam int MAX_LIM = (DEVSLP_LIM > SLUMBER_LIM)
                           ? ((DEVSLP_LIM > PARTIAL_LIM) ? DEVSLP_LIM : PARTIAL_LIM)
                           : ((SLUMBER_LIM > PARTIAL_LIM) ? SLUMBER_LIM : PARTIAL_LIM);
    localparam int CW = $clog2(MAX_LIM + 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (src)
            K_PARTIAL: lim = CW'(PARTIAL_LIM);
            K_SLUMBER: lim = CW'(SLUMBER_LIM);
            default:   lim = CW'(DEVSLP_LIM);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!waking) begin
            cnt_q <= '0;
        end else if (cnt_q <= lim) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign err = waking && !ready && (cnt_q == lim);
endmodule

// File: rtl/sata_lpm_ctrl.sv
module sata_lpm_ctrl
    import sata_lpm_pkg::*;
#(
    parameter int IDLE_W      = 16,
    parameter int PARTIAL_LIM = 1000,
    parameter int SLUMBER_LIM = 1000000,
    parameter int DEVSLP_LIM  = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              agg_en,
    input  logic              agg_slumber,
    input  logic [3:0]        ipm_restrict,
    input  logic              dipm_en,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              dev_present,
    input  logic              port_idle,
    input  logic              new_cmd,
    input  logic              dev_lp_req,
    input  logic [1:0]        dev_lp_kind,
    input  logic              dev_wake,
    input  logic              phy_ready,
    output logic [1:0]        phy_mode,
    output logic [3:0]        status_ipm,
    output logic              wake_err
);
    lpm_state_t state_q, state_d;
    lp_kind_t   src_q, src_d, go_kind;
    logic       idle_hit, in_active, in_wake;

    assign in_active = (state_q == S_ACTIVE);
    assign in_wake   = (state_q == S_WAKE);

    lpm_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (in_active && port_idle && agg_en),
        .clear    (new_cmd),
        .limit    (idle_limit),
        .hit      (idle_hit)
    );

    lpm_entry_policy u_policy (
        .agg_en       (agg_en),
        .agg_slumber  (agg_slumber),
        .idle_hit     (idle_hit),
        .ipm_restrict (ipm_restrict),
        .dipm_en      (dipm_en),
        .dev_lp_req   (dev_lp_req),
        .dev_lp_kind  (dev_lp_kind),
        .go_kind      (go_kind)
    );

    lpm_wake_timer #(
        .PARTIAL_LIM (PARTIAL_LIM),
        .SLUMBER_LIM (SLUMBER_LIM),
        .DEVSLP_LIM  (DEVSLP_LIM)
    ) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .waking (in_wake),
        .src    (src_q),
        .ready  (phy_ready),
        .err    (wake_err)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        if (!dev_present) begin
            state_d = S_NODEV;                       // T_DETACH
        end else begin
            unique case (state_q)
                S_NODEV: state_d = S_ACTIVE;          // T_ATTACH
                S_ACTIVE: begin
                    if (!new_cmd) begin
                        unique case (go_kind)         // T_HOST_ENTER / T_DEV_ENTER
                            K_PARTIAL: state_d = S_PARTIAL;
                            K_SLUMBER: state_d = S_SLUMBER;
                            K_DEVSLP:  state_d = S_DEVSLP;
                            default:   state_d = S_ACTIVE;
                        endcase
                    end
                end
                S_PARTIAL, S_SLUMBER, S_DEVSLP: begin
                    if (new_cmd || dev_wake) begin    // T_EXIT
                        state_d = S_WAKE;
                        src_d   = (state_q == S_PARTIAL) ? K_PARTIAL :
                                  (state_q == S_SLUMBER) ? K_SLUMBER : K_DEVSLP;
                    end
                end
                S_WAKE: if (phy_ready) state_d = S_ACTIVE; // T_READY
                default: state_d = S_NODEV;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_NODEV;
            src_q   <= K_PARTIAL;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // outputs
    always_comb begin
        phy_mode   = 2'd0;
        status_ipm = ST_CODE_NODEV;
        unique case (state_q)
            S_NODEV:   status_ipm = ST_CODE_NODEV;
            S_ACTIVE:  status_ipm = ST_CODE_ACTIVE;
            S_PARTIAL: begin phy_mode = 2'd1; status_ipm = ST_CODE_PARTIAL; end
            S_SLUMBER: begin phy_mode = 2'd2; status_ipm = ST_CODE_SLUMBER; end
            S_DEVSLP:  begin phy_mode = 2'd3; status_ipm = ST_CODE_DEVSLP;  end
            S_WAKE: begin
                unique case (src_q)
                    K_PARTIAL: status_ipm = ST_CODE_PARTIAL;
                    K_SLUMBER: status_ipm = ST_CODE_SLUMBER;
                    default:   status_ipm = ST_CODE_DEVSLP;
                endcase
            end
            default: status_ipm = ST_CODE_NODEV;
        endcase
    end
endmodule

// File: rtl/sata_lpm_chk.sv
module sata_lpm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dev_present,
    input logic       agg_en,
    input logic [3:0] ipm_restrict,
    input logic       dipm_en,
    input logic       dev_lp_req,
    input logic [1:0] dev_lp_kind,
    input logic       phy_ready,
    input logic [1:0] phy_mode,
    input logic [3:0] status_ipm,
    input logic       wake_err
);
    p_detach_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_present |=> (status_ipm == 4'd0 && phy_mode == 2'd0));

    p_codes_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_ipm inside {4'd0, 4'd1, 4'd2, 4'd6, 4'd8});

    p_no_agg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_ipm == 4'd1 && !agg_en && !dev_lp_req && dev_present)
        |=> status_ipm == 4'd1);

    p_restrict_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_ipm == 4'd1 && ipm_restrict == 4'd3 && dev_present &&
         !(dev_lp_req && dipm_en && dev_lp_kind == 2'd2))
        |=> status_ipm == 4'd1);

    p_ready_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_ipm inside {4'd2, 4'd6, 4'd8} && phy_mode == 2'd0 &&
         phy_ready && dev_present) |=> status_ipm == 4'd1);

    p_err_in_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_err |-> (phy_mode == 2'd0 && status_ipm inside {4'd2, 4'd6, 4'd8}));

    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_err |=> !wake_err);
endmodule

bind sata_lpm_ctrl sata_lpm_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_present  (dev_present),
    .agg_en       (agg_en),
    .ipm_restrict (ipm_restrict),
    .dipm_en      (dipm_en),
    .dev_lp_req   (dev_lp_req),
    .dev_lp_kind  (dev_lp_kind),
    .phy_ready    (phy_ready),
    .phy_mode     (phy_mode),
    .status_ipm   (status_ipm),
    .wake_err     (wake_err)
);

// File: tb/sim_sata_lpm_ctrl.sv
module sim_sata_lpm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 6;
    localparam int PL = 6;
    localparam int SL = 12;
    localparam int DL = 20;

    logic clk = 0, rst_n = 0;
    logic agg_en = 0, agg_slumber = 0, dipm_en = 0;
    logic [3:0] ipm_restrict = 0;
    logic [IW-1:0] idle_limit = 6'd4;
    logic dev_present = 1, port_idle = 0, new_cmd = 0;
    logic dev_lp_req = 0, dev_wake = 0, phy_ready = 0;
    logic [1:0] dev_lp_kind = 0;
    logic [1:0] phy_mode;
    logic [3:0] status_ipm;
    logic wake_err;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sata_lpm_ctrl #(.IDLE_W(IW), .PARTIAL_LIM(PL), .SLUMBER_LIM(SL), .DEVSLP_LIM(DL)) u0 (
        .clk(clk), .rst_n(rst_n), .agg_en(agg_en), .agg_slumber(agg_slumber),
        .ipm_restrict(ipm_restrict), .dipm_en(dipm_en), .idle_limit(idle_limit),
        .dev_present(dev_present), .port_idle(port_idle), .new_cmd(new_cmd),
        .dev_lp_req(dev_lp_req), .dev_lp_kind(dev_lp_kind), .dev_wake(dev_wake),
        .phy_ready(phy_ready), .phy_mode(phy_mode), .status_ipm(status_ipm),
        .wake_err(wake_err));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance n rising edges, land on the falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wake_up(input bit by_cmd, input int code);
        port_idle = 0;
        phy_ready = 0;
        if (by_cmd) new_cmd = 1; else dev_wake = 1;
        step(1);
        new_cmd = 0; dev_wake = 0;
        chk("R6 status held in wake", status_ipm, code);
        chk("R6 phy_mode in wake", phy_mode, 0);
        phy_ready = 1;
        step(1);
        chk("R6 ready returns active", status_ipm, 1);
        phy_ready = 0;
    endtask

    task automatic t_reset;
        #1;
        chk("R1 status in reset", status_ipm, 0);
        chk("R1 phy_mode in reset", phy_mode, 0);
        @(negedge clk);
        rst_n = 1;
        step(1);
        chk("R1 attach to active", status_ipm, 1);
    endtask

    task automatic t_host_partial;
        agg_en = 1; agg_slumber = 0; ipm_restrict = 0; idle_limit = 4;
        port_idle = 1;
        step(4);
        chk("R2 still active at limit", status_ipm, 1);
        step(1);
        chk("R2 partial entered", status_ipm, 2);
        chk("R8 phy_mode partial", phy_mode, 1);
        wake_up(1, 2);
    endtask

    task automatic t_host_slumber_timeout;
        agg_slumber = 1;
        port_idle = 1;
        step(5);
        chk("R2 slumber entered", status_ipm, 6);
        chk("R8 phy_mode slumber", phy_mode, 2);
        port_idle = 0;
        dev_wake = 1;
        step(1);
        dev_wake = 0;
        step(SL - 1);
        chk("R7 no err before slumber limit", wake_err, 0);
        step(1);
        chk("R7 err at slumber limit", wake_err, 1);
        step(1);
        chk("R7 err single pulse", wake_err, 0);
        chk("R6 still waking", status_ipm, 6);
        phy_ready = 1;
        step(1);
        chk("R6 active after late ready", status_ipm, 1);
        phy_ready = 0;
    endtask

    task automatic t_no_agg;
        agg_en = 0;
        port_idle = 1;
        step(20);
        chk("R3 no host entry", status_ipm, 1);
        port_idle = 0;
        agg_en = 1;
        step(1);
    endtask

    task automatic t_restrict;
        port_idle = 0; step(1);
        agg_slumber = 1; ipm_restrict = 2; port_idle = 1;
        step(20);
        chk("R4 slumber forbidden", status_ipm, 1);
        agg_slumber = 0; ipm_restrict = 3;
        step(20);
        chk("R4 both forbidden", status_ipm, 1);
        port_idle = 0; step(1);
        agg_slumber = 1; ipm_restrict = 1; port_idle = 1;
        step(5);
        chk("R4 slumber allowed under 1", status_ipm, 6);
        wake_up(1, 6);
        agg_slumber = 0; ipm_restrict = 5; port_idle = 1;
        step(5);
        chk("R4 value 5 no restriction", status_ipm, 2);
        wake_up(0, 2);
        agg_en = 0; ipm_restrict = 0;
    endtask

    task automatic t_device;
        dipm_en = 0; dev_lp_kind = 1; dev_lp_req = 1;
        step(1);
        dev_lp_req = 0;
        chk("R5 ignored without enable", status_ipm, 1);
        dipm_en = 1; dev_lp_req = 1;
        step(1);
        dev_lp_req = 0;
        chk("R5 device slumber", status_ipm, 6);
        wake_up(0, 6);
        ipm_restrict = 3; dev_lp_kind = 2; dev_lp_req = 1;
        step(1);
        dev_lp_req = 0;
        chk("R5 device sleep unrestricted", status_ipm, 8);
        chk("R8 phy_mode devsleep", phy_mode, 3);
        new_cmd = 1;
        step(1);
        new_cmd = 0;
        step(DL - 1);
        chk("R7 no err before devsleep limit", wake_err, 0);
        step(1);
        chk("R7 err at devsleep limit", wake_err, 1);
        phy_ready = 1; step(1); phy_ready = 0;
        chk("R6 active after devsleep", status_ipm, 1);
        ipm_restrict = 1; dev_lp_kind = 0; dev_lp_req = 1;
        step(1);
        dev_lp_req = 0;
        chk("R5 restricted partial refused", status_ipm, 1);
        ipm_restrict = 0; dev_lp_req = 1;
        step(1);
        dev_lp_req = 0;
        chk("R5 device partial", status_ipm, 2);
        new_cmd = 1; step(1); new_cmd = 0;
        step(PL);
        chk("R7 err at partial limit", wake_err, 1);
        phy_ready = 1; step(1); phy_ready = 0;
        dipm_en = 0;
    endtask

    task automatic t_detach;
        agg_en = 1; agg_slumber = 0; port_idle = 1;
        step(5);
        chk("R9 precondition partial", status_ipm, 2);
        dev_present = 0;
        step(1);
        chk("R9 detach status", status_ipm, 0);
        chk("R9 detach phy_mode", phy_mode, 0);
        port_idle = 0;
        dev_present = 1;
        step(1);
        chk("R1 reattach active", status_ipm, 1);
    endtask

    task automatic t_cmd_restart;
        idle_limit = 4; port_idle = 1;
        step(3);
        new_cmd = 1; step(1); new_cmd = 0;
        step(3);
        chk("R10 idle count restarted", status_ipm, 1);
        step(2);
        chk("R10 entry after restart", status_ipm, 2);
        wake_up(1, 2);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_host_partial();
        t_host_slumber_timeout();
        t_no_agg();
        t_restrict();
        t_device();
        t_detach();
        t_cmd_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule